// File: doc/BRIEF.md
# Configuration Command Handshake Unit

This unit provides a three-register command window on a simple register bus. Software places an argument in a data register, issues a command by writing a control register, and polls a status register to learn whether the command completed and whether it was recognised. Two commands are understood: a system shutdown and a system reboot. Each one produces a single-cycle request pulse on a dedicated output. The command runs at once: the unit marks it complete, flags any unrecognised code as an error, and clears the start bit in the stored control word without further help from software.

The window exists only on one board variant. A parameter holds the board type of the instance. The registers are live only when that value equals the enabling type, 0x190. On any other variant the three offsets behave like undecoded space. An error flag pulses for one cycle whenever the bus touches an offset that the unit does not serve, so neighbouring logic can report bad accesses.

Top module: `cfgCmdUnit`

## Requirements
- R1: After reset, the data, control and status registers all read 0, and the shutdown, reboot and error outputs are low.
- R2: The data register at byte offset 0xA0 stores all 32 bits of a write and returns them on a later read.
- R3: A write to the control register at offset 0xA4 stores the write data with bits 19 and 18 forced to 0. Bit 31 of the stored word is then cleared, so a read returns the data with bits 31, 19 and 18 cleared.
- R4: Every control write sets status bit 0 (complete). Status bit 1 (error) is set when the write data, with bits 19:18 cleared, is neither 0xC0800000 nor 0xC0900000, and is cleared otherwise.
- R5: A control write whose masked value is 0xC0800000 pulses `shutdownReq` high for exactly the one cycle after the write. A masked value of 0xC0900000 pulses `rebootReq` in the same way. No other access raises either output.
- R6: A write to the status register at offset 0xA8 stores only bits 1:0 of the write data. Reads return those bits with every upper bit 0.
- R7: Read data is registered. `rdData` shows the addressed register in the cycle after `rdEn` and is 0 in every other cycle.
- R8: When `BOARD_TYPE` differs from 0x190, reads of offsets 0xA0, 0xA4 and 0xA8 return 0. Writes to them change no state and raise neither request output.
- R9: A read or write to any offset not served by the unit (including the three offsets when the unit is inactive) pulses `badAccess` high for the one cycle after the access. Served accesses leave it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe for one cycle |
| rdEn | input | 1 | Read strobe for one cycle |
| addr | input | ADDR_W | Byte offset of the access |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, valid the cycle after rdEn |
| shutdownReq | output | 1 | One-cycle shutdown request |
| rebootReq | output | 1 | One-cycle reboot request |
| badAccess | output | 1 | One-cycle flag for an access to an unserved offset |

## Verification
A wrong command decode shows up in the cycle after the control write: a request pulse is missing or misplaced. It is confirmed on the next status read, where the error bit is wrong. A mask error on the control register shows on the first read back, as a stale bit 31, 19 or 18. A status register that keeps too many bits shows when the upper read bits are non-zero. A decode that ignores the board type shows on the inactive instance as non-zero read data, as a request pulse, or as a missing `badAccess` one cycle after the access.

// File: rtl/cfgCmdPkg.sv
package cfgCmdPkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_STAT = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrData;
    logic   wrCtrl;
    logic   wrStat;
    rdSel_e rdSel;
  } cmdStrobe_t;
endpackage

// File: rtl/cfgCmdCtrl.sv
module cfgCmdCtrl
  import cfgCmdPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] OFF_DATA = 'h0A0,
  parameter logic [ADDR_W-1:0] OFF_CTRL = 'h0A4,
  parameter logic [ADDR_W-1:0] OFF_STAT = 'h0A8,
  parameter bit UNIT_ON = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output cmdStrobe_t        strobe,
  output logic              badAccess
);
  logic hitData, hitCtrl, hitStat, served;

  always_comb begin
    hitData = UNIT_ON && (addr == OFF_DATA);
    hitCtrl = UNIT_ON && (addr == OFF_CTRL);
    hitStat = UNIT_ON && (addr == OFF_STAT);
    served  = hitData || hitCtrl || hitStat;

    strobe.wrData = wrEn && hitData;
    strobe.wrCtrl = wrEn && hitCtrl;
    strobe.wrStat = wrEn && hitStat;
    if (rdEn && hitData)      strobe.rdSel = SEL_DATA;
    else if (rdEn && hitCtrl) strobe.rdSel = SEL_CTRL;
    else if (rdEn && hitStat) strobe.rdSel = SEL_STAT;
    else                      strobe.rdSel = SEL_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) badAccess <= 1'b0;
    else     badAccess <= (wrEn || rdEn) && !served;
  end
endmodule

// File: rtl/cfgCmdDatapath.sv
module cfgCmdDatapath
  import cfgCmdPkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] SHUT_CODE   = 'hC080_0000,
  parameter logic [DATA_W-1:0] REBOOT_CODE = 'hC090_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  cmdStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              shutdownReq,
  output logic              rebootReq
);
  localparam logic [DATA_W-1:0] FIELD_MASK = DATA_W'(32'h000C_0000);
  localparam logic [DATA_W-1:0] START_BIT  = DATA_W'(1) << (DATA_W - 1);

  logic [DATA_W-1:0] dataReg, ctrlReg, ctrlMasked;
  logic [1:0]        statReg;
  logic              isShut, isReboot;

  always_comb begin
    ctrlMasked = wrData & ~FIELD_MASK;
    isShut     = (ctrlMasked == SHUT_CODE);
    isReboot   = (ctrlMasked == REBOOT_CODE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dataReg     <= '0;
      ctrlReg     <= '0;
      statReg     <= 2'b00;
      shutdownReq <= 1'b0;
      rebootReq   <= 1'b0;
      rdData      <= '0;
    end else begin
      shutdownReq <= strobe.wrCtrl && isShut;
      rebootReq   <= strobe.wrCtrl && isReboot;
      if (strobe.wrData) dataReg <= wrData;
      if (strobe.wrCtrl) begin
        ctrlReg <= ctrlMasked & ~START_BIT;
        statReg <= {!(isShut || isReboot), 1'b1};
      end else if (strobe.wrStat) begin
        statReg <= wrData[1:0];
      end
      case (strobe.rdSel)
        SEL_DATA: rdData <= dataReg;
        SEL_CTRL: rdData <= ctrlReg;
        SEL_STAT: rdData <= {{(DATA_W-2){1'b0}}, statReg};
        default:  rdData <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cfgCmdUnit.sv
module cfgCmdUnit
  import cfgCmdPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [11:0] BOARD_TYPE  = 12'h190,
  parameter logic [11:0] ACTIVE_TYPE = 12'h190
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              shutdownReq,
  output logic              rebootReq,
  output logic              badAccess
);
  localparam bit UNIT_ON = (BOARD_TYPE == ACTIVE_TYPE);

  cmdStrobe_t strobe;
  logic       unitOn;
  assign unitOn = UNIT_ON;

  cfgCmdCtrl #(
    .ADDR_W  (ADDR_W),
    .UNIT_ON (UNIT_ON)
  ) uCtrl (
    .clk       (clk),
    .rst       (rst),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .addr      (addr),
    .strobe    (strobe),
    .badAccess (badAccess)
  );

  cfgCmdDatapath #(
    .DATA_W (DATA_W)
  ) uDp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .wrData      (wrData),
    .rdData      (rdData),
    .shutdownReq (shutdownReq),
    .rebootReq   (rebootReq)
  );
endmodule

// File: rtl/cfgCmdChecker.sv
module cfgCmdChecker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              unitOn,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdData,
  input logic              shutdownReq,
  input logic              rebootReq,
  input logic              badAccess
);
  // R5: request outputs last a single cycle
  a_r5_shut_single: assert property (@(posedge clk) disable iff (rst)
    shutdownReq |=> !shutdownReq);
  a_r5_reboot_single: assert property (@(posedge clk) disable iff (rst)
    rebootReq |=> !rebootReq);
  // R5: never both requests together
  a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(shutdownReq && rebootReq));
  // R5: a request follows a control-register write
  a_r5_shut_cause: assert property (@(posedge clk) disable iff (rst)
    shutdownReq |-> $past(wrEn && addr == ADDR_W'('hA4)));
  // R8: an inactive unit stays silent
  a_r8_inactive_quiet: assert property (@(posedge clk) disable iff (rst)
    !unitOn |-> (!shutdownReq && !rebootReq && rdData == '0));
  // R9: an error flag follows a bus access
  a_r9_bad_cause: assert property (@(posedge clk) disable iff (rst)
    badAccess |-> $past(wrEn || rdEn));
  // R7: read data is zero unless a read preceded it
  a_r7_rd_idle: assert property (@(posedge clk) disable iff (rst)
    !$past(rdEn) |-> rdData == '0);
endmodule

bind cfgCmdUnit cfgCmdChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk         (clk),
  .rst         (rst),
  .unitOn      (unitOn),
  .wrEn        (wrEn),
  .rdEn        (rdEn),
  .addr        (addr),
  .rdData      (rdData),
  .shutdownReq (shutdownReq),
  .rebootReq   (rebootReq),
  .badAccess   (badAccess)
);

// File: tb/tb_cfgCmdUnit.sv
module tb_cfgCmdUnit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData, rdDataOff;
  logic        shutdownReq, rebootReq, badAccess;
  logic        shutOff, rebootOff, badOff;
  int          errors = 0, checks = 0, cycles = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  cfgCmdUnit dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .shutdownReq(shutdownReq), .rebootReq(rebootReq), .badAccess(badAccess)
  );

  cfgCmdUnit #(.BOARD_TYPE(12'h178)) dutOff (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdDataOff), .shutdownReq(shutOff), .rebootReq(rebootOff), .badAccess(badOff)
  );

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [11:0] a;
    logic [31:0] d;
    logic [31:0] expRd;
    logic        expShut;
    logic        expReboot;
    logic        expBad;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 12'h0A0, 32'h1234_5678, 32'h0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 write
    '{1'b0, 1'b1, 12'h0A0, 32'h0,         32'h1234_5678, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 read
    '{1'b1, 1'b0, 12'h0A4, 32'hC080_0000, 32'h0, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 shutdown
    '{1'b0, 1'b1, 12'h0A4, 32'h0,         32'h4080_0000, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 start bit cleared
    '{1'b0, 1'b1, 12'h0A8, 32'h0,         32'h1, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 complete
    '{1'b1, 1'b0, 12'h0A4, 32'hC09C_0000, 32'h0, 1'b0, 1'b1, 1'b0, 4'd5},  // R5 reboot, masked field
    '{1'b0, 1'b1, 12'h0A4, 32'h0,         32'h4090_0000, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 bits 19:18 cleared
    '{1'b0, 1'b1, 12'h0A8, 32'h0,         32'h1, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
    '{1'b1, 1'b0, 12'h0A4, 32'h800C_0001, 32'h0, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 unknown code
    '{1'b0, 1'b1, 12'h0A4, 32'h0,         32'h0000_0001, 1'b0, 1'b0, 1'b0, 4'd3},  // R3
    '{1'b0, 1'b1, 12'h0A8, 32'h0,         32'h3, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 error bit
    '{1'b1, 1'b0, 12'h0A8, 32'hFFFF_FFFC, 32'h0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
    '{1'b0, 1'b1, 12'h0A8, 32'h0,         32'h0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
    '{1'b1, 1'b0, 12'h0A8, 32'h0000_0007, 32'h0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
    '{1'b0, 1'b1, 12'h0A8, 32'h0,         32'h3, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 upper bits dropped
    '{1'b0, 1'b1, 12'h010, 32'h0,         32'h0, 1'b0, 1'b0, 1'b1, 4'd9},  // R9 bad read
    '{1'b1, 1'b0, 12'h0AC, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0, 1'b1, 4'd9}   // R9 bad write
  };

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive one access at a negedge; outputs are checked at the next negedge
  task automatic access(input logic w, input logic r, input logic [11:0] a, input logic [31:0] d);
    wrEn = w; rdEn = r; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0; addr = '0; wrData = '0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !finished) begin
        errors++;
        $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(1, "shutdown after reset", {31'b0, shutdownReq}, 32'h0);
    access(1'b0, 1'b1, 12'h0A0, 32'h0); chk(1, "data after reset", rdData, 32'h0);
    access(1'b0, 1'b1, 12'h0A4, 32'h0); chk(1, "ctrl after reset", rdData, 32'h0);
    access(1'b0, 1'b1, 12'h0A8, 32'h0); chk(1, "stat after reset", rdData, 32'h0);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      access(VECS[i].wr, VECS[i].rd, VECS[i].a, VECS[i].d);
      chk(int'(VECS[i].req), $sformatf("vec%0d outputs", i),
          {rdData[27:0], shutdownReq, rebootReq, badAccess, 1'b0},
          {VECS[i].expRd[27:0], VECS[i].expShut, VECS[i].expReboot, VECS[i].expBad, 1'b0});
      chk(int'(VECS[i].req), $sformatf("vec%0d rd upper", i), {28'b0, rdData[31:28]}, {28'b0, VECS[i].expRd[31:28]});
    end

    // R5: pulse lasts one cycle only
    access(1'b1, 1'b0, 12'h0A4, 32'hC080_0000);
    chk(5, "shutdown pulse", {31'b0, shutdownReq}, 32'h1);
    chk(8, "inactive no shutdown", {31'b0, shutOff}, 32'h0);
    chk(8, "inactive flags bad", {31'b0, badOff}, 32'h1);
    @(negedge clk);
    chk(5, "shutdown drops", {31'b0, shutdownReq}, 32'h0);

    // R7: read data returns to zero the cycle after a read
    access(1'b0, 1'b1, 12'h0A0, 32'h0);
    chk(7, "read data", rdData, 32'h1234_5678);
    @(negedge clk);
    chk(7, "read data idle", rdData, 32'h0);

    // R8: inactive unit ignores writes and reads as zero
    access(1'b1, 1'b0, 12'h0A0, 32'hDEAD_BEEF);
    access(1'b0, 1'b1, 12'h0A0, 32'h0);
    chk(8, "inactive data read", rdDataOff, 32'h0);
    chk(8, "active data read", rdData, 32'hDEAD_BEEF);
    chk(9, "active served no bad", {31'b0, badAccess}, 32'h0);
    access(1'b1, 1'b0, 12'h0A4, 32'hC090_0000);
    chk(8, "inactive no reboot", {31'b0, rebootOff}, 32'h0);
    access(1'b0, 1'b1, 12'h0A8, 32'h0);
    chk(8, "inactive stat read", rdDataOff, 32'h0);
    chk(8, "inactive stat bad", {31'b0, badOff}, 32'h1);

    // R1: reset mid-run clears state
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    access(1'b0, 1'b1, 12'h0A0, 32'h0); chk(1, "data after second reset", rdData, 32'h0);
    access(1'b0, 1'b1, 12'h0A8, 32'h0); chk(1, "stat after second reset", rdData, 32'h0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule